// File: doc/BRIEF.md
# Low-Power Mode Status Flags

This block holds one 32-bit register that records which low-power states the system and its power domains have passed through since the flags were last cleared. Five hardware event inputs set sticky flags: system stop, system standby, standby of domain 0, standby of domain 1, and a hold-wakeup flag. Software reads the register at any time. A write with the clear-command bit set clears all flags at once. The same register also holds three per-domain deep-sleep select bits and two control bits, one to hold a companion processor and one to keep a domain running. These are plain read-write storage and drive output ports.

The block has two active-low resets. The power-on reset clears everything. The system reset clears everything except the system standby flag, which survives so that software can tell after a system reset that standby was entered. A domain standby flag cannot be cleared by the command while its domain is still in standby. The block does not control entry into or exit from any power state. The states arrive as inputs.

Top module: `lpm_flag_regs`

## Requirements
- R1: While `por_n` is low, every register bit is 0. After its release, `reg_rdata` reads 0 and all control outputs are 0.
- R2: A one-cycle pulse on an event input sets its flag at the next clock edge, and the flag stays set. The flag positions are: hold-wakeup at bit 4, stop at bit 5, system standby at bit 6, domain 0 standby at bit 7, domain 1 standby at bit 8.
- R3: A write with bit 9 set is the clear command. At the next edge it clears the hold-wakeup, stop and system standby flags, and each domain standby flag whose domain is not in standby.
- R4: A system reset (`sys_rst_n` low, `por_n` high) clears the hold-wakeup, stop and both domain standby flags and all control bits. It leaves the system standby flag unchanged.
- R5: While `dom_in_stby[i]` is high, the clear command leaves domain standby flag i set. A system reset or a power-on reset still clears it.
- R6: Bit 9 always reads as 0. Bits 3 and 12 to 31 also read as 0.
- R7: Every write loads the deep-sleep selects from bits 0 to 2, the hold control from bit 10 and the keep-run control from bit 11. These bits read back and drive `dsel_o`, `hold_ctl_o` and `keep_run_o`. Without a write they do not change.
- R8: A write has no effect on the flag bits 4 to 8 other than through the clear command.
- R9: When a set event and the clear command occur in the same cycle, the flag for that event is set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| evt_hold_wake | input | 1 | Hold-wakeup event pulse |
| evt_stop | input | 1 | System stop event pulse |
| evt_sys_stby | input | 1 | System standby event pulse |
| evt_dom_stby | input | 2 | Domain standby event pulses, one per domain |
| dom_in_stby | input | 2 | Domain currently in standby, one per domain |
| dsel_o | output | 3 | Per-domain deep-sleep selects |
| hold_ctl_o | output | 1 | Hold control bit |
| keep_run_o | output | 1 | Keep-run control bit |

## Verification
The properties assume that every input is synchronous to `clk`. They also assume that no register write occurs while the system reset is held, so that the system standby flag can change only through its own event during that time. The stimulus changes inputs only on the falling edge and keeps `reg_we` low in every reset cycle. The domain-in-standby levels are held over several cycles, never toggled per cycle, so that the blocked-clear case is exercised with the level present on the command edge.

// File: rtl/lpm_flag_pkg.sv
package lpm_flag_pkg;
  localparam int REG_W   = 32;
  localparam int DSEL_W  = 3;
  localparam int NUM_DOM = 2;

  // bit positions of the status/control word
  localparam int B_DSEL  = 0;
  localparam int B_HOLDF = 4;
  localparam int B_STOPF = 5;
  localparam int B_SBF   = 6;
  localparam int B_DSBF  = 7;
  localparam int B_CLR   = 9;
  localparam int B_HOLD  = 10;
  localparam int B_KEEP  = 11;

  typedef struct packed {
    logic [DSEL_W-1:0] dsel;
    logic              hold;
    logic              keep;
  } ctl_t;

  // next state of a sticky flag: set dominates, clear may be blocked
  function automatic logic flag_next(logic q, logic set, logic clr, logic blk);
    return set | (q & ~(clr & ~blk));
  endfunction

  function automatic ctl_t unpack_ctl(logic [REG_W-1:0] w);
    ctl_t c;
    c.dsel = w[B_DSEL +: DSEL_W];
    c.hold = w[B_HOLD];
    c.keep = w[B_KEEP];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(ctl_t c, logic holdf, logic stopf,
                                                   logic sbf, logic [NUM_DOM-1:0] dsbf);
    logic [REG_W-1:0] r;
    r = '0;
    r[B_DSEL +: DSEL_W]  = c.dsel;
    r[B_HOLDF]           = holdf;
    r[B_STOPF]           = stopf;
    r[B_SBF]             = sbf;
    r[B_DSBF +: NUM_DOM] = dsbf;
    r[B_HOLD]            = c.hold;
    r[B_KEEP]            = c.keep;
    return r;
  endfunction
endpackage

// File: rtl/lpm_sticky_flag.sv
module lpm_sticky_flag #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  input  logic [W-1:0] blk_i,
  output logic [W-1:0] q_o
);
  import lpm_flag_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= flag_next(q_o[i], set_i[i], clr_i, blk_i[i]);
    end
  end
endmodule

// File: rtl/lpm_ctl_store.sv
module lpm_ctl_store (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we_i,
  input  logic [lpm_flag_pkg::REG_W-1:0]  wdata_i,
  output lpm_flag_pkg::ctl_t              ctl_o
);
  import lpm_flag_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctl_o <= '0;
    else if (we_i) ctl_o <= unpack_ctl(wdata_i);
  end
endmodule

// File: rtl/lpm_flag_regs.sv
module lpm_flag_regs
  import lpm_flag_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               sys_rst_n,
  input  logic               reg_we,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               evt_hold_wake,
  input  logic               evt_stop,
  input  logic               evt_sys_stby,
  input  logic [NUM_DOM-1:0] evt_dom_stby,
  input  logic [NUM_DOM-1:0] dom_in_stby,
  output logic [DSEL_W-1:0]  dsel_o,
  output logic               hold_ctl_o,
  output logic               keep_run_o
);
  // any reset class clears the system-reset domain
  logic rst_sys_n;
  assign rst_sys_n = por_n & sys_rst_n;

  // clear command: write strobe with command bit, never stored
  logic clr_cmd;
  assign clr_cmd = reg_we & reg_wdata[B_CLR];

  logic [1:0]         core_q;    // [1]=stop, [0]=hold-wakeup
  logic               sbf_q;
  logic [NUM_DOM-1:0] dsbf_q;
  ctl_t               ctl_q;

  lpm_sticky_flag #(.W(2)) u_core_flags (
    .clk  (clk),
    .rst_n(rst_sys_n),
    .set_i({evt_stop, evt_hold_wake}),
    .clr_i(clr_cmd),
    .blk_i(2'b00),
    .q_o  (core_q)
  );

  lpm_sticky_flag #(.W(1)) u_sys_stby_flag (
    .clk  (clk),
    .rst_n(por_n),
    .set_i(evt_sys_stby),
    .clr_i(clr_cmd),
    .blk_i(1'b0),
    .q_o  (sbf_q)
  );

  lpm_sticky_flag #(.W(NUM_DOM)) u_dom_flags (
    .clk  (clk),
    .rst_n(rst_sys_n),
    .set_i(evt_dom_stby),
    .clr_i(clr_cmd),
    .blk_i(dom_in_stby),
    .q_o  (dsbf_q)
  );

  lpm_ctl_store u_ctl (
    .clk    (clk),
    .rst_n  (rst_sys_n),
    .we_i   (reg_we),
    .wdata_i(reg_wdata),
    .ctl_o  (ctl_q)
  );

  assign reg_rdata  = pack_status(ctl_q, core_q[0], core_q[1], sbf_q, dsbf_q);
  assign dsel_o     = ctl_q.dsel;
  assign hold_ctl_o = ctl_q.hold;
  assign keep_run_o = ctl_q.keep;
endmodule

// File: rtl/lpm_flag_regs_chk.sv
module lpm_flag_regs_chk
  import lpm_flag_pkg::*;
(
  input logic               clk,
  input logic               por_n,
  input logic               sys_rst_n,
  input logic               reg_we,
  input logic               clr_cmd,
  input logic [REG_W-1:0]   reg_rdata,
  input logic               evt_stop,
  input logic               evt_sys_stby,
  input logic [NUM_DOM-1:0] dom_in_stby,
  input logic [DSEL_W-1:0]  dsel_o,
  input logic               hold_ctl_o,
  input logic               keep_run_o
);
  logic any_rst_n;
  assign any_rst_n = por_n & sys_rst_n;

  // R2: stop event visible after one edge
  a_r2_stop_sets: assert property (@(posedge clk) disable iff (!any_rst_n)
    evt_stop |=> reg_rdata[B_STOPF]);

  // R3: clear without a competing set removes the stop flag
  a_r3_clear_stop: assert property (@(posedge clk) disable iff (!any_rst_n)
    (clr_cmd && !evt_stop) |=> !reg_rdata[B_STOPF]);

  // R4: system reset alone keeps the system standby flag
  a_r4_sbf_survives: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && !evt_sys_stby && !clr_cmd) |=> $stable(reg_rdata[B_SBF]));

  // R5: clear is blocked while the domain is still in standby
  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    a_r5_dom_blocked: assert property (@(posedge clk) disable iff (!any_rst_n)
      (dom_in_stby[i] && reg_rdata[B_DSBF+i]) |=> reg_rdata[B_DSBF+i]);
  end

  // R6: command bit never reads back
  a_r6_cmd_reads_zero: assert property (@(posedge clk) disable iff (!por_n)
    !reg_rdata[B_CLR]);

  // R7: control bits hold without a write
  a_r7_ctl_stable: assert property (@(posedge clk) disable iff (!any_rst_n)
    !reg_we |=> ($stable(dsel_o) && $stable(hold_ctl_o) && $stable(keep_run_o)));

  // R9: set dominates a same-cycle clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!any_rst_n)
    (evt_stop && clr_cmd) |=> reg_rdata[B_STOPF]);
endmodule

bind lpm_flag_regs lpm_flag_regs_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .sys_rst_n   (sys_rst_n),
  .reg_we      (reg_we),
  .clr_cmd     (clr_cmd),
  .reg_rdata   (reg_rdata),
  .evt_stop    (evt_stop),
  .evt_sys_stby(evt_sys_stby),
  .dom_in_stby (dom_in_stby),
  .dsel_o      (dsel_o),
  .hold_ctl_o  (hold_ctl_o),
  .keep_run_o  (keep_run_o)
);

// File: tb/lpm_flag_regs_test.sv
module lpm_flag_regs_test;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        evt_hold_wake = 1'b0;
  logic        evt_stop = 1'b0;
  logic        evt_sys_stby = 1'b0;
  logic [1:0]  evt_dom_stby = '0;
  logic [1:0]  dom_in_stby = '0;
  logic [2:0]  dsel_o;
  logic        hold_ctl_o;
  logic        keep_run_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] CLR  = 32'h0000_0200;
  localparam logic [31:0] ALLF = 32'h0000_01F0;

  always #2.5 clk = ~clk;

  lpm_flag_regs uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_hold_wake(evt_hold_wake), .evt_stop(evt_stop), .evt_sys_stby(evt_sys_stby),
    .evt_dom_stby(evt_dom_stby), .dom_in_stby(dom_in_stby),
    .dsel_o(dsel_o), .hold_ctl_o(hold_ctl_o), .keep_run_o(keep_run_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [31:0] v);
    reg_we = 1'b1; reg_wdata = v;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic set_all_flags();
    evt_hold_wake = 1; evt_stop = 1; evt_sys_stby = 1; evt_dom_stby = 2'b11;
    tick();
    evt_hold_wake = 0; evt_stop = 0; evt_sys_stby = 0; evt_dom_stby = 2'b00;
  endtask

  task automatic sys_reset();
    sys_rst_n = 1'b0; tick(); sys_rst_n = 1'b1; tick();
  endtask

  task automatic por_reset();
    por_n = 1'b0; sys_rst_n = 1'b0; tick(); tick();
    por_n = 1'b1; sys_rst_n = 1'b1; tick();
  endtask

  task automatic t_reset();
    check("R1 rdata after por", reg_rdata, 32'h0);
    check("R1 ctl outputs after por", {29'h0, dsel_o}, 32'h0);
    check("R1 hold/keep after por", {30'h0, hold_ctl_o, keep_run_o}, 32'h0);
  endtask

  task automatic t_stop_sticky();
    evt_stop = 1; tick(); evt_stop = 0;
    check("R2 stop flag set", reg_rdata, 32'h20);
    tick(); tick();
    check("R2 stop flag sticky", reg_rdata, 32'h20);
    evt_sys_stby = 1; tick(); evt_sys_stby = 0;
    check("R2 sys standby flag set", reg_rdata, 32'h60);
  endtask

  task automatic t_clear_all();
    set_all_flags();
    check("R2 all flags set", reg_rdata, ALLF);
    wr(CLR);
    check("R3 clear command clears flags", reg_rdata, 32'h0);
    wr(CLR | 32'h0000_0004);
    check("R6 command bit reads zero", reg_rdata, 32'h4);
    wr(32'h0);
  endtask

  task automatic t_ctl_rw();
    wr(32'h0000_0C07);
    check("R7 ctl readback", reg_rdata, 32'h0C07);
    check("R7 ctl outputs", {27'h0, dsel_o, hold_ctl_o, keep_run_o}, 32'h1F);
    tick(); tick();
    check("R7 ctl holds without write", reg_rdata, 32'h0C07);
    wr(32'hFFFF_FDFF);
    check("R6 R8 unused and flag bits ignored", reg_rdata, 32'h0C07);
    wr(32'h0000_0402);
    check("R7 ctl reload", {27'h0, dsel_o, hold_ctl_o, keep_run_o}, 32'h0A);
    set_all_flags();
    wr(32'h0000_0402);
    check("R8 write keeps flags", reg_rdata, ALLF | 32'h402);
    wr(CLR);
  endtask

  task automatic t_sys_reset();
    set_all_flags();
    wr(32'h0000_0805);
    sys_reset();
    check("R4 system reset keeps only sys standby", reg_rdata, 32'h40);
    check("R4 system reset clears ctl", {27'h0, dsel_o, hold_ctl_o, keep_run_o}, 32'h0);
    por_reset();
    check("R1 por clears sys standby", reg_rdata, 32'h0);
  endtask

  task automatic t_dom_block();
    dom_in_stby = 2'b01;
    evt_dom_stby = 2'b11; tick(); evt_dom_stby = 2'b00;
    check("R2 domain flags set", reg_rdata, 32'h180);
    wr(CLR);
    check("R5 clear blocked for domain 0 only", reg_rdata, 32'h080);
    dom_in_stby = 2'b00; tick();
    check("R5 flag stays after standby ends", reg_rdata, 32'h080);
    wr(CLR);
    check("R5 clear once domain left standby", reg_rdata, 32'h0);
    dom_in_stby = 2'b10;
    evt_dom_stby = 2'b10; tick(); evt_dom_stby = 2'b00;
    sys_reset();
    check("R5 system reset clears blocked flag", reg_rdata, 32'h0);
    dom_in_stby = 2'b00; tick();
  endtask

  task automatic t_set_wins();
    evt_hold_wake = 1; tick(); evt_hold_wake = 0;
    check("R2 hold-wakeup flag set", reg_rdata, 32'h10);
    evt_stop = 1; reg_we = 1; reg_wdata = CLR;
    tick();
    evt_stop = 0; reg_we = 0; reg_wdata = '0;
    check("R9 set beats clear, other flag cleared", reg_rdata, 32'h20);
    wr(CLR);
    check("R3 clear after collision", reg_rdata, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) tick();
    por_n = 1'b1; sys_rst_n = 1'b1;
    tick();
    t_reset();
    t_stop_sticky();
    t_clear_all();
    t_ctl_rw();
    t_sys_reset();
    t_dom_block();
    t_set_wins();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule